// File: doc/BRIEF.md
# Three-Operand Integer Adder with Operand Shaping

This block adds three integer operands in one clock. Each operand may first be cut down to one of its half-words and then negated on its own. In the register form, the partial sum of the first two operands may also be moved by half a word before the third operand is added. It is meant for a shader-style integer ALU lane.

The issue stage drives the three operands and their controls together with a valid strobe. The result comes out of a register one clock later, together with a valid flag. The arithmetic wraps modulo 2^DATA_W. No condition flags are produced.

Top module: `tri_add3`

## Requirements
- R1: `result` equals op_a + op_b + op_c modulo 2^32 after operand shaping. Carries out of bit 31 are lost.
- R2: When `reg_form`=1, each operand's height select shapes that operand as follows: 0 passes it whole; 1 keeps bits 15:0 and zero-extends them; 2 shifts it logically right by 16.
- R3: When `reg_form`=1, height select 3 turns that operand into zero. Its negate flag then leaves it at zero.
- R4: When `reg_form`=0, the height selects and `shift_mode` have no effect. The result is the plain three-way sum with the negate flags still applied.
- R5: A set negate flag replaces its operand with the two's complement of that operand. Negation happens after height shaping.
- R6: When `reg_form`=1, `shift_mode` acts on A+B as follows: 0 leaves it unchanged; 2 shifts it left by 16 and drops the bits pushed above bit 31; 3 acts like 0. Operand C is added after the shift.
- R7: When `reg_form`=1 and `shift_mode`=1, A+B is formed at 33 bits and shifted logically right by 16, so its carry-out lands in bit 16. C is then added.
- R8: `out_valid` equals `in_valid` delayed by one clock. A result is captured on every clock where `in_valid` is high.
- R9: A synchronous active-high `rst` clears `out_valid` and `result` to zero.
- R10: While `in_valid` is low, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| op_c | input | 32 | Operand C |
| reg_form | input | 1 | 1 = register form (height and shift enabled) |
| height_a | input | 2 | Height select for A |
| height_b | input | 2 | Height select for B |
| height_c | input | 2 | Height select for C |
| neg_a | input | 1 | Negate A |
| neg_b | input | 1 | Negate B |
| neg_c | input | 1 | Negate C |
| shift_mode | input | 2 | Shift applied to A+B |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Registered sum |

## Verification
The bench builds the block only with the default DATA_W of 32, so the half-word is 16 bits. That width lets hand-computed vectors reach the exact corners. One case is the 33-bit carry of A+B landing in bit 16 under a right shift. Another is a left shift whose partial sum overflows to zero. Others are a negated upper half-word, a zeroed unsupported height, and the reserved shift code. Directed steps cover latency, hold and mid-run reset.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;
  localparam int HT_W = 2;
  localparam int SM_W = 2;

  typedef enum logic [HT_W-1:0] {
    HT_FULL = 2'd0,
    HT_LOW  = 2'd1,
    HT_HIGH = 2'd2,
    HT_BAD  = 2'd3
  } height_e;

  typedef enum logic [SM_W-1:0] {
    SM_NONE  = 2'd0,
    SM_RIGHT = 2'd1,
    SM_LEFT  = 2'd2,
    SM_RSVD  = 2'd3
  } shift_e;
endpackage

// File: rtl/tri_add_opnd.sv
module tri_add_opnd
  import tri_add_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              reg_form_i,
  input  height_e           height_i,
  input  logic              neg_i,
  output logic [DATA_W-1:0] opnd_o
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] pick_half(input logic [DATA_W-1:0] v, input height_e h);
    case (h)
      HT_FULL: return v;
      HT_LOW:  return {{(DATA_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
      HT_HIGH: return v >> HALF_W;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] twos_neg(input logic [DATA_W-1:0] v, input logic n);
    return n ? ((~v) + DATA_W'(1)) : v;
  endfunction

  // shaped operand before negation, visible to the assertions
  logic [DATA_W-1:0] picked;
  assign picked = reg_form_i ? pick_half(opnd_i, height_i) : opnd_i;
  assign opnd_o = twos_neg(picked, neg_i);

  // R2: upper half-word leaves the top half clear when not negated
  a_r2_high_top_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_form_i && height_i == HT_HIGH && !neg_i) |-> opnd_o[DATA_W-1:HALF_W] == '0);
  // R2: lower half-word is zero-extended
  a_r2_low_top_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_form_i && height_i == HT_LOW && !neg_i) |-> opnd_o[DATA_W-1:HALF_W] == '0);
  // R3: unsupported height yields zero whatever the negate flag
  a_r3_bad_is_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_form_i && height_i == HT_BAD) |-> opnd_o == '0);
  // R4: outside the register form the operand is untouched
  a_r4_form_bypass: assert property (@(posedge clk) disable iff (rst)
    (!reg_form_i && !neg_i) |-> opnd_o == opnd_i);
  // R5: negated value plus shaped value wraps to zero
  a_r5_neg_cancels: assert property (@(posedge clk) disable iff (rst)
    neg_i |-> (opnd_o + picked) == '0);
endmodule

// File: rtl/tri_add_merge.sv
module tri_add_merge
  import tri_add_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic              reg_form_i,
  input  shift_e            mode_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] shift_pair(input logic [DATA_W:0] s, input shift_e m);
    case (m)
      SM_RIGHT: return DATA_W'(s >> HALF_W);
      SM_LEFT:  return s[DATA_W-1:0] << HALF_W;
      default:  return s[DATA_W-1:0];
    endcase
  endfunction

  logic [DATA_W:0]   pair_sum;
  logic              pair_carry;
  logic [DATA_W-1:0] shifted;

  assign pair_sum   = {1'b0, a_i} + {1'b0, b_i};
  assign pair_carry = pair_sum[DATA_W];
  assign shifted    = reg_form_i ? shift_pair(pair_sum, mode_i) : pair_sum[DATA_W-1:0];
  assign sum_o      = shifted + c_i;

  // R7: carry-out of A+B appears at bit HALF_W after a right shift
  a_r7_carry_lands: assert property (@(posedge clk) disable iff (rst)
    (reg_form_i && mode_i == SM_RIGHT) |-> shifted[DATA_W-HALF_W] == pair_carry);
  // R7: nothing above the carry position after a right shift
  a_r7_top_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_form_i && mode_i == SM_RIGHT) |-> shifted[DATA_W-1:DATA_W-HALF_W+1] == '0);
  // R6: left shift leaves the low half clear
  a_r6_left_low_clear: assert property (@(posedge clk) disable iff (rst)
    (reg_form_i && mode_i == SM_LEFT) |-> shifted[HALF_W-1:0] == '0);
endmodule

// File: rtl/tri_add3.sv
module tri_add3
  import tri_add_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] op_c,
  input  logic              reg_form,
  input  logic [HT_W-1:0]   height_a,
  input  logic [HT_W-1:0]   height_b,
  input  logic [HT_W-1:0]   height_c,
  input  logic              neg_a,
  input  logic              neg_b,
  input  logic              neg_c,
  input  logic [SM_W-1:0]   shift_mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int NUM_OPS = 3;

  logic [DATA_W-1:0] raw     [NUM_OPS];
  logic [HT_W-1:0]   hts     [NUM_OPS];
  logic              negs    [NUM_OPS];
  logic [DATA_W-1:0] prepped [NUM_OPS];
  logic [DATA_W-1:0] sum_w;

  assign raw[0]  = op_a;     assign raw[1]  = op_b;     assign raw[2]  = op_c;
  assign hts[0]  = height_a; assign hts[1]  = height_b; assign hts[2]  = height_c;
  assign negs[0] = neg_a;    assign negs[1] = neg_b;    assign negs[2] = neg_c;

  for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_opnd
    tri_add_opnd #(.DATA_W(DATA_W)) u_opnd (
      .clk        (clk),
      .rst        (rst),
      .opnd_i     (raw[gi]),
      .reg_form_i (reg_form),
      .height_i   (height_e'(hts[gi])),
      .neg_i      (negs[gi]),
      .opnd_o     (prepped[gi])
    );
  end

  tri_add_merge #(.DATA_W(DATA_W)) u_merge (
    .clk        (clk),
    .rst        (rst),
    .a_i        (prepped[0]),
    .b_i        (prepped[1]),
    .c_i        (prepped[2]),
    .reg_form_i (reg_form),
    .mode_i     (shift_e'(shift_mode)),
    .sum_o      (sum_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= sum_w;
    end
  end

  // R8: valid output trails the strobe by one clock
  a_r8_valid_lag: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid));
  // R8: accepted sum is what appears next cycle
  a_r8_capture: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> result == $past(sum_w));
  // R10: no strobe, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
endmodule

// File: tb/tri_add3_tb_top.sv
`timescale 1ns/1ps
module tri_add3_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, op_c = '0;
  logic        reg_form = 1'b0;
  logic [1:0]  height_a = '0, height_b = '0, height_c = '0;
  logic        neg_a = 1'b0, neg_b = 1'b0, neg_c = 1'b0;
  logic [1:0]  shift_mode = '0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tri_add3 dut_i (
    .clk, .rst, .in_valid, .op_a, .op_b, .op_c, .reg_form,
    .height_a, .height_b, .height_c, .neg_a, .neg_b, .neg_c,
    .shift_mode, .out_valid, .result
  );

  typedef struct packed {
    logic [31:0] a, b, c;
    logic        form;
    logic [1:0]  ha, hb, hc;
    logic        na, nb, nc;
    logic [1:0]  mode;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // fields: a, b, c, form, ha, hb, hc, na, nb, nc, mode, expected, requirement number
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h1, 32'h2, 32'h3, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h6, 4'd1},              // R1
    '{32'hFFFFFFFF, 32'h1, 32'h5, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h5, 4'd1},      // R1 wrap
    '{32'h12345678, 32'h0, 32'h0, 1'b0, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h12345678, 4'd4}, // R4
    '{32'h12345678, 32'h1, 32'h0, 1'b1, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h5679, 4'd2},   // R2 low
    '{32'hABCD0000, 32'h10000, 32'h10, 1'b1, 2'd2, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 32'hABDE, 4'd2}, // R2 high
    '{32'hDEADBEEF, 32'h7, 32'h8, 1'b1, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 32'hF, 4'd3},      // R3
    '{32'hA, 32'h3, 32'h2, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 2'd0, 32'h5, 4'd5},             // R5
    '{32'h00050003, 32'h100, 32'h0, 1'b1, 2'd2, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'hFB, 4'd5},   // R5 after height
    '{32'h1234, 32'h1, 32'h5, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 32'h12350005, 4'd6},   // R6 left
    '{32'h18000, 32'h8000, 32'h7, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 32'h7, 4'd6},      // R6 left drop
    '{32'hFFFF0000, 32'h10000, 32'h1, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 32'h10001, 4'd7}, // R7 carry
    '{32'h12340000, 32'h10000, 32'h10, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 32'h1245, 4'd7}, // R7
    '{32'h10000, 32'h0, 32'h0, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 32'h10000, 4'd4},     // R4 mode off
    '{32'h4, 32'h5, 32'h6, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3, 32'hF, 4'd6},             // R6 reserved
    '{32'h20000, 32'h0, 32'h0, 1'b1, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'hFFFE, 4'd7}       // R7 negated
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    op_a = v.a; op_b = v.b; op_c = v.c; reg_form = v.form;
    height_a = v.ha; height_b = v.hb; height_c = v.hc;
    neg_a = v.na; neg_b = v.nb; neg_c = v.nc; shift_mode = v.mode;
    in_valid = vld;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    vec_t held;
    // R9: reset state, with a strobe held high during reset
    @(negedge clk); drive(VECS[0], 1'b1);
    repeat (3) @(posedge clk);
    #1;
    check("R9 out_valid in reset", {31'b0, out_valid}, 32'h0);
    check("R9 result in reset", result, 32'h0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;

    // table walk (R1-R7 cases by number)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); drive(VECS[i], 1'b1);
      @(posedge clk); #1;
      check($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].exp);
      check("R8 out_valid high", {31'b0, out_valid}, 32'h1);
    end

    // R8: single strobe then idle
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    check("R8 out_valid drops", {31'b0, out_valid}, 32'h0);

    // R10: operands change without strobe
    held = VECS[NV-1];
    @(negedge clk); drive(VECS[1], 1'b0);
    repeat (2) @(posedge clk);
    #1;
    check("R10 result held", result, held.exp);

    // R3: negated unsupported height stays zero
    @(negedge clk);
    drive('{32'h5, 32'h1, 32'h0, 1'b1, 2'd3, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h1, 4'd3}, 1'b1);
    @(posedge clk); #1;
    check("R3 negated bad height", result, 32'h1);

    // R9: reset mid-run clears a live result
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    check("R9 mid-run out_valid", {31'b0, out_valid}, 32'h0);
    check("R9 mid-run result", result, 32'h0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1;

    finish_run();
  end
endmodule